// File: doc/BRIEF.md
# Configurable UART Frame Engine

This block is the serial core of an asynchronous serial port. It turns bytes from a transmit source into framed bit streams on a transmit line, and it turns bit streams arriving on a receive line back into bytes for a receive sink. Baud rate, character width, parity and stop length are all set by static configuration inputs. These inputs must be held stable while a frame is in flight. Received characters come with a parity-error flag and a framing-error flag.

The pins can be adapted to the board. Each of the receive, transmit, clear-to-send and request-to-send levels has its own inversion control. A loopback mode routes the transmitter straight into the receiver and ignores the receive pin. With hardware flow control enabled, the transmitter only starts a frame while clear-to-send is asserted. The CTS input is assumed to be synchronous to `clk`. The receive pin passes through a two-stage synchronizer. Buffering and interrupt logic sit outside this block.

The transmitter has five states. TX_IDLE moves to TX_START when a byte is accepted. TX_START moves to TX_DATA after one bit time. TX_DATA moves to TX_PARITY, or to TX_STOP when parity is off, after the last data bit. TX_PARITY moves to TX_STOP after one bit time. TX_STOP returns to TX_IDLE after the stop length.

The receiver has six states. RX_IDLE moves to RX_START on a low line. RX_START checks the line at half a bit time: it returns to RX_IDLE if the line is high again, and goes on to RX_DATA if it is still low. RX_DATA samples each bit at its middle, then moves to RX_PARITY or RX_STOP. RX_PARITY moves to RX_STOP. RX_STOP delivers the character. It then returns to RX_IDLE if the stop bit was high, and moves to RX_WAIT_HIGH if it was low. RX_WAIT_HIGH returns to RX_IDLE once the line is high.

Top module: `uart_frame_engine`

## Requirements
- R1: After reset, with no inversion, `txd` is high, `rx_valid` is low, and `tx_ready` is high whenever flow control does not block.
- R2: A bit lasts P clock cycles, where P is `cfg_div`, or 2 when `cfg_div` is below 2. A frame is a low start bit, then the data bits LSB first, then the optional parity bit, then a high stop. A byte is accepted on a clock edge where `tx_valid` and `tx_ready` are both high. The start bit begins on the first cycle after that edge.
- R3: `cfg_len` selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8.
- R4: The parity bit is present only when `cfg_par_en` is 1. With `cfg_par_odd` at 0 it makes the count of ones in data plus parity even. With `cfg_par_odd` at 1 it makes that count odd.
- R5: The stop time is (P × h) / 2 cycles, rounded down. `cfg_stop` sets h: codes 0 and 1 give h = 2, code 2 gives h = 3 (1.5 bits), and code 3 gives h = 4 (2 bits). `tx_ready` rises exactly when the stop time ends.
- R6: Each received character raises `rx_valid` for exactly one cycle. `rx_data` then holds the data bits LSB-aligned, with the unused upper bits at zero.
- R7: When parity is enabled, `rx_par_err` is 1 if the received parity bit does not match the setting. When parity is disabled, `rx_par_err` is 0.
- R8: `rx_frm_err` is 1 when the stop bit is low at its mid-point. The receiver then waits for a high line before it looks for the next start bit.
- R9: `inv_txd` inverts `txd`. `inv_rxd` inverts the sampled `rxd`. `inv_cts` inverts `cts`. `rts` equals `rts_ctl` XOR `inv_rts`.
- R10: With `cfg_loop` at 1, the receiver decodes the transmitter's own frames and the level on `rxd` has no effect.
- R11: With `cfg_cts_gate` at 1, `tx_ready` stays low and no frame starts while `cts` XOR `inv_cts` is 0. A pending byte starts once that value becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | 20 | Clock cycles per bit |
| cfg_len | input | 2 | Data-width code |
| cfg_stop | input | 2 | Stop-length code |
| cfg_par_en | input | 1 | Parity enable |
| cfg_par_odd | input | 1 | Odd parity when 1, even when 0 |
| cfg_loop | input | 1 | Internal loopback |
| cfg_cts_gate | input | 1 | Transmit flow control enable |
| inv_rxd | input | 1 | Invert the receive pin |
| inv_txd | input | 1 | Invert the transmit pin |
| inv_cts | input | 1 | Invert the clear-to-send pin |
| inv_rts | input | 1 | Invert the request-to-send pin |
| rts_ctl | input | 1 | Request-to-send level before inversion |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Transmit byte accepted this cycle if valid |
| rx_valid | output | 1 | One-cycle pulse marking a received character |
| rx_data | output | 8 | Received character |
| rx_par_err | output | 1 | Parity mismatch for this character |
| rx_frm_err | output | 1 | Stop bit read low for this character |
| rxd | input | 1 | Serial receive pin |
| cts | input | 1 | Clear-to-send pin |
| txd | output | 1 | Serial transmit pin |
| rts | output | 1 | Request-to-send pin |

## Verification
A wrong transmit state or bit counter shows up directly on `txd`. The bad level appears within the same bit period, so the bench samples every bit at its centre. A wrong stop count moves the rise of `tx_ready` by whole cycles, and the bench measures that rise exactly. A wrong receive state or sample point gives a corrupted `rx_data`, a spurious error flag, or a missing or extra `rx_valid` pulse. That result appears one half bit into the stop bit, where the scoreboard compares every character against the byte that was sent.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PARITY,
        TX_STOP
    } tx_state_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP,
        RX_WAIT_HIGH
    } rx_state_t;

    // index of the last data bit for a width code (5..8 bits)
    function automatic logic [2:0] last_bit_idx(input logic [1:0] code);
        return 3'd4 + {1'b0, code};
    endfunction

endpackage

// File: rtl/uart_fe_timing.sv
module uart_fe_timing #(
    parameter int DIV_W = 20
) (
    input  logic [DIV_W-1:0] div,
    input  logic [1:0]       stop_code,
    output logic [DIV_W-1:0] per,
    output logic [DIV_W-1:0] half,
    output logic [DIV_W:0]   stop_cyc
);
    logic [2:0]       halves;
    logic [DIV_W+2:0] prod;

    always_comb begin
        per      = (div < DIV_W'(2)) ? DIV_W'(2) : div;
        half     = per >> 1;
        halves   = (stop_code == 2'd0) ? 3'd2 : 3'd1 + {1'b0, stop_code};
        prod     = (DIV_W+3)'(per) * (DIV_W+3)'(halves);
        stop_cyc = prod[DIV_W+1:1];
    end
endmodule

// File: rtl/uart_fe_sync.sv
module uart_fe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/uart_fe_tx.sv
module uart_fe_tx
    import uart_fe_pkg::*;
#(
    parameter int DIV_W = 20,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] per,
    input  logic [DIV_W:0]   stop_cyc,
    input  logic [1:0]       len_code,
    input  logic             par_en,
    input  logic             par_odd,
    input  logic             cts_ok,
    input  logic             tx_valid,
    input  logic [DW-1:0]    tx_data,
    output logic             tx_ready,
    output logic             tx_line
);
    tx_state_t        state_q, state_d;
    logic [DIV_W:0]   cnt_q, cnt_d;
    logic [DW-1:0]    sh_q, sh_d;
    logic [2:0]       nbit_q, nbit_d;
    logic             par_q, par_d;
    logic             bit_done;

    assign bit_done = (cnt_q == {1'b0, per} - 1'b1);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + 1'b1;
        sh_d    = sh_q;
        nbit_d  = nbit_q;
        par_d   = par_q;
        unique case (state_q)
            TX_IDLE: begin
                cnt_d = '0;
                if (tx_valid && cts_ok) begin
                    state_d = TX_START;
                    sh_d    = tx_data;
                    par_d   = par_odd;
                    nbit_d  = '0;
                end
            end
            TX_START: begin
                if (bit_done) begin
                    cnt_d   = '0;
                    state_d = TX_DATA;
                end
            end
            TX_DATA: begin
                if (bit_done) begin
                    cnt_d  = '0;
                    par_d  = par_q ^ sh_q[0];
                    sh_d   = sh_q >> 1;
                    nbit_d = nbit_q + 3'd1;
                    if (nbit_q == last_bit_idx(len_code))
                        state_d = par_en ? TX_PARITY : TX_STOP;
                end
            end
            TX_PARITY: begin
                if (bit_done) begin
                    cnt_d   = '0;
                    state_d = TX_STOP;
                end
            end
            TX_STOP: begin
                if (cnt_q == stop_cyc - 1'b1) begin
                    cnt_d   = '0;
                    state_d = TX_IDLE;
                end
            end
            default: state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            cnt_q   <= '0;
            sh_q    <= '0;
            nbit_q  <= '0;
            par_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            sh_q    <= sh_d;
            nbit_q  <= nbit_d;
            par_q   <= par_d;
        end
    end

    always_comb begin
        tx_ready = (state_q == TX_IDLE) && cts_ok;
        unique case (state_q)
            TX_START:  tx_line = 1'b0;
            TX_DATA:   tx_line = sh_q[0];
            TX_PARITY: tx_line = par_q;
            default:   tx_line = 1'b1;
        endcase
    end
endmodule

// File: rtl/uart_fe_rx.sv
module uart_fe_rx
    import uart_fe_pkg::*;
#(
    parameter int DIV_W = 20,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] per,
    input  logic [DIV_W-1:0] half,
    input  logic [1:0]       len_code,
    input  logic             par_en,
    input  logic             par_odd,
    input  logic             line,
    output logic             rx_valid,
    output logic [DW-1:0]    rx_data,
    output logic             rx_par_err,
    output logic             rx_frm_err
);
    rx_state_t        state_q, state_d;
    logic [DIV_W:0]   cnt_q, cnt_d;
    logic [DW-1:0]    sh_q, sh_d;
    logic [2:0]       nbit_q, nbit_d;
    logic             acc_q, acc_d;
    logic             perr_q, perr_d;
    logic             emit, emit_fe;
    logic             bit_done;

    assign bit_done = (cnt_q == {1'b0, per} - 1'b1);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + 1'b1;
        sh_d    = sh_q;
        nbit_d  = nbit_q;
        acc_d   = acc_q;
        perr_d  = perr_q;
        emit    = 1'b0;
        emit_fe = 1'b0;
        unique case (state_q)
            RX_IDLE: begin
                cnt_d = '0;
                if (!line) state_d = RX_START;
            end
            RX_START: begin
                if (cnt_q == {1'b0, half} - 1'b1) begin
                    cnt_d   = '0;
                    state_d = line ? RX_IDLE : RX_DATA;
                    sh_d    = '0;
                    nbit_d  = '0;
                    acc_d   = par_odd;
                    perr_d  = 1'b0;
                end
            end
            RX_DATA: begin
                if (bit_done) begin
                    cnt_d        = '0;
                    sh_d[nbit_q] = line;
                    acc_d        = acc_q ^ line;
                    nbit_d       = nbit_q + 3'd1;
                    if (nbit_q == last_bit_idx(len_code))
                        state_d = par_en ? RX_PARITY : RX_STOP;
                end
            end
            RX_PARITY: begin
                if (bit_done) begin
                    cnt_d   = '0;
                    perr_d  = (line != acc_q);
                    state_d = RX_STOP;
                end
            end
            RX_STOP: begin
                if (bit_done) begin
                    cnt_d   = '0;
                    emit    = 1'b1;
                    emit_fe = !line;
                    state_d = line ? RX_IDLE : RX_WAIT_HIGH;
                end
            end
            RX_WAIT_HIGH: begin
                cnt_d = '0;
                if (line) state_d = RX_IDLE;
            end
            default: state_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
            sh_q    <= '0;
            nbit_q  <= '0;
            acc_q   <= 1'b0;
            perr_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            sh_q    <= sh_d;
            nbit_q  <= nbit_d;
            acc_q   <= acc_d;
            perr_q  <= perr_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_valid   <= 1'b0;
            rx_data    <= '0;
            rx_par_err <= 1'b0;
            rx_frm_err <= 1'b0;
        end else begin
            rx_valid <= emit;
            if (emit) begin
                rx_data    <= sh_q;
                rx_par_err <= perr_q && par_en;
                rx_frm_err <= emit_fe;
            end
        end
    end
endmodule

// File: rtl/uart_frame_engine.sv
module uart_frame_engine #(
    parameter int DIV_W       = 20,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [1:0]       cfg_len,
    input  logic [1:0]       cfg_stop,
    input  logic             cfg_par_en,
    input  logic             cfg_par_odd,
    input  logic             cfg_loop,
    input  logic             cfg_cts_gate,
    input  logic             inv_rxd,
    input  logic             inv_txd,
    input  logic             inv_cts,
    input  logic             inv_rts,
    input  logic             rts_ctl,
    input  logic             tx_valid,
    input  logic [DW-1:0]    tx_data,
    output logic             tx_ready,
    output logic             rx_valid,
    output logic [DW-1:0]    rx_data,
    output logic             rx_par_err,
    output logic             rx_frm_err,
    input  logic             rxd,
    input  logic             cts,
    output logic             txd,
    output logic             rts
);
    logic [DIV_W-1:0] per, half;
    logic [DIV_W:0]   stop_cyc;
    logic             tx_line, rxd_s, rx_line, cts_ok;

    uart_fe_timing #(.DIV_W(DIV_W)) i_timing (
        .div(cfg_div), .stop_code(cfg_stop),
        .per(per), .half(half), .stop_cyc(stop_cyc)
    );

    uart_fe_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .d(rxd ^ inv_rxd), .q(rxd_s)
    );

    assign cts_ok  = !cfg_cts_gate || (cts ^ inv_cts);
    assign rx_line = cfg_loop ? tx_line : rxd_s;
    assign txd     = tx_line ^ inv_txd;
    assign rts     = rts_ctl ^ inv_rts;

    uart_fe_tx #(.DIV_W(DIV_W), .DW(DW)) i_tx (
        .clk(clk), .rst_n(rst_n), .per(per), .stop_cyc(stop_cyc),
        .len_code(cfg_len), .par_en(cfg_par_en), .par_odd(cfg_par_odd),
        .cts_ok(cts_ok), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .tx_line(tx_line)
    );

    uart_fe_rx #(.DIV_W(DIV_W), .DW(DW)) i_rx (
        .clk(clk), .rst_n(rst_n), .per(per), .half(half),
        .len_code(cfg_len), .par_en(cfg_par_en), .par_odd(cfg_par_odd),
        .line(rx_line), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err)
    );
endmodule

// File: rtl/uart_fe_chk.sv
module uart_fe_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_cts_gate,
    input logic       cts,
    input logic       inv_cts,
    input logic       cfg_par_en,
    input logic [1:0] cfg_len,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       tx_line,
    input logic       rx_valid,
    input logic [7:0] rx_data,
    input logic       rx_par_err
);
    a_r11_cts_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_cts_gate && !(cts ^ inv_cts)) |-> !tx_ready);

    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_line);

    a_r5_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    a_r7_no_parity_err: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !cfg_par_en) |-> !rx_par_err);

    a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && cfg_len == 2'd0) |-> (rx_data[7:5] == 3'b000));
endmodule

bind uart_frame_engine uart_fe_chk i_chk (
    .clk(clk), .rst_n(rst_n), .cfg_cts_gate(cfg_cts_gate), .cts(cts),
    .inv_cts(inv_cts), .cfg_par_en(cfg_par_en), .cfg_len(cfg_len),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_line(tx_line),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_par_err(rx_par_err)
);

// File: tb/test_uart_frame_engine.sv
module test_uart_frame_engine;
    localparam int CLK_PERIOD = 10;
    localparam int DIV = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [19:0] cfg_div = 20'(DIV);
    logic [1:0]  cfg_len = 2'd3, cfg_stop = 2'd1;
    logic cfg_par_en = 0, cfg_par_odd = 0, cfg_loop = 1, cfg_cts_gate = 0;
    logic inv_rxd = 0, inv_txd = 0, inv_cts = 0, inv_rts = 0, rts_ctl = 0;
    logic tx_valid = 0;
    logic [7:0] tx_data = 0;
    logic tx_ready, rx_valid, rx_par_err, rx_frm_err, txd, rts;
    logic [7:0] rx_data;
    logic rxd = 1, cts = 1;

    int n_chk = 0, n_err = 0;
    bit done = 0;
    logic [9:0] exp_q[$];

    uart_frame_engine i_uart_frame_engine (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops expected {frm,par,data}
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (exp_q.size() == 0) check(0, "R6 unexpected character", rx_data, 0);
            else begin
                logic [9:0] e;
                e = exp_q.pop_front();
                check({rx_frm_err, rx_par_err, rx_data} == e, "R6 scoreboard",
                      {rx_frm_err, rx_par_err, rx_data}, e);
            end
        end
    end

    function automatic int nbits();
        return 5 + int'(cfg_len);
    endfunction

    function automatic logic par_of(input logic [7:0] d);
        logic p;
        p = cfg_par_odd;
        for (int i = 0; i < nbits(); i++) p ^= d[i];
        return p;
    endfunction

    // send one byte, check every bit on txd and the frame length
    task automatic send(input logic [7:0] d, input string req);
        logic [7:0] m;
        int nb, elapsed, halves, fr;
        logic lvl;
        nb = 1 + nbits() + (cfg_par_en ? 1 : 0);
        m = 8'((1 << nbits()) - 1) & d;
        exp_q.push_back({2'b00, m});
        tx_data = d; tx_valid = 1;
        @(posedge clk); #1 tx_valid = 0;
        elapsed = 0;
        for (int b = 0; b <= nb; b++) begin
            int t;
            t = b * DIV + DIV / 2;
            repeat (t - elapsed) @(posedge clk);
            elapsed = t; #1;
            if (b == 0) lvl = 0;
            else if (b <= nbits()) lvl = d[b-1];
            else if (b == nb && !cfg_par_en) lvl = 1;
            else if (b < nb) lvl = par_of(d);
            else lvl = 1;
            if (b == nb) lvl = 1;
            else if (b == nb - 1 && cfg_par_en) lvl = par_of(d);
            check(txd == (lvl ^ inv_txd), {req, " bit"}, txd, lvl ^ inv_txd);
        end
        while (!tx_ready && elapsed < 400) begin
            @(posedge clk); elapsed++; #1;
        end
        halves = (cfg_stop == 0) ? 2 : int'(cfg_stop) + 1;
        fr = nb * DIV + (DIV * halves) / 2;
        check(elapsed == fr, "R5 frame length", elapsed, fr);
        repeat (4) @(posedge clk); #1;
    endtask

    // bit-bang a frame on rxd
    task automatic drive(input logic [7:0] d, input logic pbit, input logic stop);
        rxd = 0 ^ inv_rxd; repeat (DIV) @(posedge clk);
        for (int i = 0; i < nbits(); i++) begin
            rxd = d[i] ^ inv_rxd; repeat (DIV) @(posedge clk);
        end
        if (cfg_par_en) begin rxd = pbit ^ inv_rxd; repeat (DIV) @(posedge clk); end
        rxd = stop ^ inv_rxd; repeat (DIV) @(posedge clk);
        rxd = 1 ^ inv_rxd; repeat (3 * DIV) @(posedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            check(0, "watchdog", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(txd == 1 && tx_ready == 1 && rx_valid == 0, "R1 reset state",
              {txd, tx_ready, rx_valid}, 3'b110);
        rst_n = 1;
        repeat (2) @(posedge clk); #1;

        // R2/R5 8 data, no parity, 1 stop (loopback R10)
        send(8'hA5, "R2 8N1");
        // R3/R4 5 bits even parity
        cfg_len = 0; cfg_par_en = 1; cfg_par_odd = 0;
        send(8'hF3, "R3 R4 5E1");
        // 6 bits odd parity, 1.5 stop
        cfg_len = 1; cfg_par_odd = 1; cfg_stop = 2;
        send(8'h2D, "R4 6O1.5");
        // 7 bits no parity, 2 stop
        cfg_len = 2; cfg_par_en = 0; cfg_stop = 3;
        send(8'h55, "R3 7N2");
        cfg_len = 3; cfg_stop = 1;

        // R10 loopback ignores rxd held low
        rxd = 0;
        send(8'h3C, "R10 loopback");
        rxd = 1;
        repeat (4 * DIV) @(posedge clk);
        cfg_loop = 0;
        repeat (4) @(posedge clk);

        // R7 parity error and good parity on external line
        cfg_par_en = 1; cfg_par_odd = 0;
        exp_q.push_back({2'b01, 8'h81});
        drive(8'h81, 1'b1, 1'b1);   // even parity of 0x81 is 0, send 1
        exp_q.push_back({2'b00, 8'h81});
        drive(8'h81, 1'b0, 1'b1);
        // R8 framing error, then recovery
        cfg_par_en = 0;
        exp_q.push_back({2'b10, 8'h6E});
        drive(8'h6E, 1'b0, 1'b0);
        exp_q.push_back({2'b00, 8'h19});
        drive(8'h19, 1'b0, 1'b1);

        // R9 inverted receive pin
        inv_rxd = 1; rxd = 0; repeat (4) @(posedge clk);
        exp_q.push_back({2'b00, 8'hC4});
        drive(8'hC4, 1'b0, 1'b1);
        inv_rxd = 0; rxd = 1; repeat (4) @(posedge clk);
        check(exp_q.size() == 0, "R6 all characters delivered", exp_q.size(), 0);

        // R9 inverted txd, rts
        inv_txd = 1; #1;
        check(txd == 0, "R9 txd inverted idle", txd, 0);
        cfg_loop = 1;
        send(8'h96, "R9 inverted txd");
        inv_txd = 0;
        rts_ctl = 1; inv_rts = 1; #1;
        check(rts == 0, "R9 rts inverted", rts, 0);
        inv_rts = 0; #1;
        check(rts == 1, "R9 rts plain", rts, 1);

        // R11 flow control
        cfg_cts_gate = 1; cts = 0; #1;
        check(tx_ready == 0, "R11 blocked", tx_ready, 0);
        tx_data = 8'h5A; tx_valid = 1;
        for (int i = 0; i < 3 * DIV; i++) begin
            @(posedge clk); #1;
            if (i == 3 * DIV - 1) check(txd == 1, "R11 no start while blocked", txd, 1);
        end
        inv_cts = 1; #1;
        check(tx_ready == 1, "R9 R11 inverted cts releases", tx_ready, 1);
        tx_valid = 0; inv_cts = 0; cts = 1;
        send(8'h5A, "R11 released frame");
        cfg_cts_gate = 0;

        repeat (2 * DIV) @(posedge clk);
        check(exp_q.size() == 0, "R10 loopback drained", exp_q.size(), 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule